// File: doc/BRIEF.md
# Serial Round-Key Nibble Selector

This block holds a 256-bit cipher key as eight 32-bit words and feeds a nibble-serial block-cipher datapath with one 4-bit slice of round key per clock. A full run covers 32 rounds of 8 nibbles, so 256 cycles. Three small counters drive the run: a 2-bit series counter (four groups of eight rounds), a 3-bit column counter (round within the series) and a 3-bit tick counter (nibble within the 32-bit word).

Two key orders are offered, chosen when a run starts. In the classic order the words go 0 up to 7 in each of the first three series and 7 down to 0 in the last. In the modified order each series starts from its own offset word and walks up, except the last series, which walks down. The word index is an offset looked up by series, plus or minus the column counter, modulo 8. The key is written word by word while the block is idle. A ready flag rises when the last nibble of round 32 has been issued.

Top module: `keynib_seq`

## Requirements
- R1: After reset `busy`, `ready`, `nib_idx` and `word_idx` are all 0.
- R2: A high `start` sampled while `busy` is 0 sets `busy`, clears `ready` and zeroes all counters at that edge, and latches `mode`. A `start` while `busy` is 1 has no effect.
- R3: During a run `nib_idx` counts 0..7 one step per cycle. The column advances when the nibble index wraps, and the series advances when both wrap. Cycle n of a run (n = 0..255) has nibble n mod 8, column (n/8) mod 8 and series n/64.
- R4: With `mode`=0 (classic) latched, `word_idx` equals the column in series 0, 1 and 2, and 7 minus the column in series 3.
- R5: With `mode`=1 (modified) latched, the word order per series is: series 0: 0,1,2,3,4,5,6,7. Series 1: 3,4,5,6,7,0,1,2. Series 2: 5,6,7,0,1,2,3,4. Series 3: 6,5,4,3,2,1,0,7.
- R6: `key_nib` equals bits 4t+3..4t of stored word w, where t=`nib_idx` and w=`word_idx`. A word is stored from `key_wdata` at address `key_addr` on an edge where `key_we` is 1 and `busy` is 0.
- R7: On the edge that ends cycle 255 of a run, `busy` falls and `ready` rises. The counters return to 0, and `ready` holds until the next accepted start.
- R8: Key writes while `busy` is 1 are ignored.
- R9: While idle with no start, `ready`, `nib_idx` and `word_idx` stay constant.
- R10: Changing `mode` during a run does not alter the running word order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (accepted when idle) |
| mode | input | 1 | 0 classic order, 1 modified order; sampled at start |
| key_we | input | 1 | Key word write enable |
| key_addr | input | 3 | Key word address |
| key_wdata | input | 32 | Key word data |
| busy | output | 1 | Run in progress; outputs below are valid |
| ready | output | 1 | Run finished |
| word_idx | output | 3 | Selected key word |
| nib_idx | output | 3 | Selected nibble within the word |
| key_nib | output | 4 | Current round-key nibble |

## Verification
A start sampled at one edge makes the first nibble visible right after that edge, so run cycle n is observed n edges later. `ready` rises exactly 256 edges after the accepting edge. The bench drives and samples one time unit after each rising edge, and it checks every one of the 256 cycles against schedule rows written out from R4 and R5. Ignored key writes and restarts are checked by the nibble values that later runs produce.

// File: rtl/keynib_seq.sv
module keynib_seq #(
  parameter int WORD_W = 32,
  parameter int NWORD  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      mode,
  input  logic                      key_we,
  input  logic [$clog2(NWORD)-1:0]  key_addr,
  input  logic [WORD_W-1:0]         key_wdata,
  output logic                      busy,
  output logic                      ready,
  output logic [$clog2(NWORD)-1:0]  word_idx,
  output logic [2:0]                nib_idx,
  output logic [3:0]                key_nib
);
  localparam int AW = $clog2(NWORD);

  logic [WORD_W-1:0] keys [NWORD];
  logic [1:0]    ser;
  logic [AW-1:0] col;
  logic [2:0]    tick;
  logic          mode_q;
  logic [AW-1:0] base;

  wire last_tick = (tick == 3'd7);
  wire last_col  = (col == AW'(NWORD - 1));
  wire last_ser  = (ser == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ser    <= '0;
      col    <= '0;
      tick   <= '0;
      busy   <= 1'b0;
      ready  <= 1'b0;
      mode_q <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        ser    <= '0;
        col    <= '0;
        tick   <= '0;
        busy   <= 1'b1;
        ready  <= 1'b0;
        mode_q <= mode;
      end
    end else begin
      tick <= tick + 3'd1;
      if (last_tick) begin
        col <= col + AW'(1);
        if (last_col) begin
          ser <= ser + 2'd1;
          if (last_ser) begin
            busy  <= 1'b0;
            ready <= 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORD; i++) keys[i] <= '0;
    end else if (key_we && !busy) begin
      keys[key_addr] <= key_wdata;
    end
  end

  always_comb begin
    if (mode_q) begin
      case (ser)
        2'd0:    base = AW'(0);
        2'd1:    base = AW'(3);
        2'd2:    base = AW'(5);
        default: base = AW'(6);
      endcase
    end else begin
      base = last_ser ? AW'(NWORD - 1) : AW'(0);
    end
  end

  assign word_idx = last_ser ? base - col : base + col;
  assign nib_idx  = tick;

  wire [WORD_W-1:0] sel_word = keys[word_idx] >> {tick, 2'b00};
  assign key_nib = sel_word[3:0];
endmodule

module keynib_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       ready,
  input logic [2:0] word_idx,
  input logic [2:0] nib_idx
);
  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && !ready && nib_idx == 3'd0)); // R2

  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || nib_idx == $past(nib_idx) + 3'd1)); // R3

  AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (ready && nib_idx == 3'd0)); // R7

  AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready && busy)); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(ready) && $stable(nib_idx) && $stable(word_idx) && !busy)); // R9
endmodule

bind keynib_seq keynib_seq_chk u_chk (.*);

// File: tb/sim_keynib_seq.sv
module sim_keynib_seq;
  logic clk = 0, rst_n = 0, start = 0, mode = 0, key_we = 0;
  logic [2:0] key_addr = 0;
  logic [31:0] key_wdata = 0;
  logic busy, ready;
  logic [2:0] word_idx, nib_idx;
  logic [3:0] key_nib;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [31:0] kmod [8];

  always #5 clk = ~clk;

  keynib_seq u0 (.*);

  int classic_row [4][8] = '{'{0,1,2,3,4,5,6,7}, '{0,1,2,3,4,5,6,7},
                             '{0,1,2,3,4,5,6,7}, '{7,6,5,4,3,2,1,0}};
  int mod_row [4][8] = '{'{0,1,2,3,4,5,6,7}, '{3,4,5,6,7,0,1,2},
                         '{5,6,7,0,1,2,3,4}, '{6,5,4,3,2,1,0,7}};

  task automatic step(); @(posedge clk); #1; endtask

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_key(int seed);
    for (int w = 0; w < 8; w++) begin
      kmod[w] = (32'h9E3779B9 * (w + 1)) ^ (seed * 32'h01010101) ^ (w << 28);
      key_we = 1; key_addr = 3'(w); key_wdata = kmod[w];
      step();
    end
    key_we = 0;
  endtask

  // run one full sequence; disturb: 1 = write key and restart mid-run, 2 = flip mode mid-run
  task automatic run(bit m, int disturb);
    int ew, en;
    mode = m; start = 1;
    step();
    start = 0;
    for (int n = 0; n < 256; n++) begin
      ew = m ? mod_row[n/64][(n/8)%8] : classic_row[n/64][(n/8)%8];
      en = n % 8;
      chk("R2/R3 busy", busy, 1);
      chk("R3 nib_idx", nib_idx, en);
      chk(m ? "R5 word_idx" : "R4 word_idx", word_idx, ew);
      chk("R6 key_nib", key_nib, int'((kmod[ew] >> (4*en)) & 32'hF));
      if (disturb == 1 && n == 100) begin
        key_we = 1; key_addr = 3'd2; key_wdata = 32'hDEADBEEF; start = 1;  // R8 and R2 ignored
      end else if (disturb == 2 && n == 70) begin
        mode = ~m;  // R10
      end else begin
        key_we = 0; start = 0;
      end
      step();
    end
    key_we = 0; start = 0;
    chk("R7 busy low", busy, 0);
    chk("R7 ready", ready, 1);
    chk("R7 counters zero", nib_idx, 0);
  endtask

  initial begin
    #3;
    chk("R1 busy", busy, 0);
    chk("R1 ready", ready, 0);
    chk("R1 nib_idx", nib_idx, 0);
    chk("R1 word_idx", word_idx, 0);
    rst_n = 1;
    step();
    load_key(1);
    run(0, 0);
    run(1, 0);
    for (int i = 0; i < 5; i++) begin
      step();
      chk("R9 ready held", ready, 1);
      chk("R9 nib_idx held", nib_idx, 0);
      chk("R9 busy idle", busy, 0);
    end
    load_key(7);
    run(1, 1);
    run(0, 1);  // kmod unchanged: second run proves the busy write was dropped (R8)
    run(0, 2);
    run(1, 2);
    mode = 0; start = 1;
    step();
    start = 0;
    chk("R2 ready cleared on start", ready, 0);
    chk("R2 busy on start", busy, 1);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(10 * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule